// File: doc/BRIEF.md
# Transparent DRAM Byte-Lane Access Path

This block gives an external tester direct access to one byte lane of a 72-bit DDR data bus through a 16-bit single-data-rate port. The bus has nine byte lanes. Each lane carries two beats per reference clock: an early (even) beat and a late (odd) beat. The 16-bit port holds both beats side by side: the early byte sits in bits 7:0 and the late byte in bits 15:8.

On a write burst, the tester's 16-bit word is placed on one chosen lane. Every other lane is driven from two programmable fill bytes, one for the early beat and one for the late beat. A write-lane code of all ones (15) sends the word to every lane at once. On a read burst, the early and late bytes of a chosen lane are registered and shown on a 16-bit status output. At the same time, the bytes of the write-selected lane are compared with the tester's word, and a mismatch flag reports the result.

Configuration is written into a staging copy. The staging copy is moved into the active copy only in a reference cycle that carries no burst. A change therefore never lands in the middle of a run of back-to-back bursts.

Top module: `tlane_access`

## Requirements
- R1: While the active enable bit is clear, `wr_go` and `rd_go` have no effect. `dq_wr_valid` and `status_valid` stay low, and `dq_wr_early`, `dq_wr_late`, `status_out` and `mismatch` keep their values.
- R2: With the block enabled and a write-lane code n in 0..8, one clock after `wr_go` is high, `dq_wr_valid` is 1. Bits 8n+7:8n of `dq_wr_early` hold `tdata_in[7:0]`, and the same bits of `dq_wr_late` hold `tdata_in[15:8]`.
- R3: On such a write, every other lane of `dq_wr_early` carries the early fill byte, and every other lane of `dq_wr_late` carries the late fill byte.
- R4: A write-lane code of 15 places `tdata_in[7:0]` and `tdata_in[15:8]` on all nine lanes.
- R5: A write-lane code from 9 to 14 selects no lane, so all nine lanes carry the fill bytes.
- R6: With the block enabled and a read-lane code n in 0..8, one clock after `rd_go` is high, `status_valid` is 1. `status_out` then equals {`dq_rd_late`[8n+7:8n], `dq_rd_early`[8n+7:8n]}, using the bus values present with `rd_go`.
- R7: A read-lane code from 9 to 15 gives `status_out` = 0 on a read.
- R8: On a read, `mismatch` is 1 exactly when `tdata_in` differs from the word {late, early} of the write-selected lane. If the write-lane code is 9..15, that word is taken as 0.
- R9: A `cfg_load` pulse stores the configuration inputs in a staging copy. The staging copy becomes active only at the end of a cycle in which both `wr_go` and `rd_go` are low. Bursts issued back to back keep the previous configuration.
- R10: After reset, all outputs are 0 and the active configuration is disabled, with zero lane codes and zero fill bytes.
- R11: `dq_wr_valid` and `status_valid` are single-cycle responses to their go inputs. Data outputs change only in the cycle their valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Stores the cfg_* inputs in the staging copy |
| cfg_enable | input | 1 | Transparent access enable |
| cfg_rd_lane | input | 4 | Lane shown on the status output |
| cfg_wr_lane | input | 4 | Lane written and compared; 15 broadcasts on writes |
| cfg_fill_early | input | 8 | Early-beat byte for lanes not selected |
| cfg_fill_late | input | 8 | Late-beat byte for lanes not selected |
| wr_go | input | 1 | Write burst this cycle |
| rd_go | input | 1 | Read burst this cycle |
| tdata_in | input | 16 | Tester word: early byte in 7:0, late byte in 15:8 |
| dq_rd_early | input | 72 | Early beat captured from the DDR bus |
| dq_rd_late | input | 72 | Late beat captured from the DDR bus |
| dq_wr_early | output | 72 | Early beat to drive on the DDR bus |
| dq_wr_late | output | 72 | Late beat to drive on the DDR bus |
| dq_wr_valid | output | 1 | Write beats valid |
| status_out | output | 16 | Selected lane read word |
| status_valid | output | 1 | Read word and mismatch valid |
| mismatch | output | 1 | Compared lane word differs from tdata_in |

## Verification
A lane decode that drifts onto the wrong index puts tester data into a fill position. That error is visible on the write buses one cycle after the burst, so each write compares all 144 output bits against a model. A staging copy that is applied too early shows up as a different lane pattern on the second burst of a back-to-back run. A stuck pending bit shows up as stale lane codes on the first burst after an idle cycle. A corrupt compare path shows up on the mismatch flag on the very read that exercises it. The random reads are arranged so that roughly half of them are meant to match.

// File: rtl/tlane_pkg.sv
package tlane_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;
    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [SEL_W-1:0] SEL_ALL = '1;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  rd_sel;
        logic [SEL_W-1:0]  wr_sel;
        logic [BYTE_W-1:0] fill_e;
        logic [BYTE_W-1:0] fill_l;
    } cfg_t;
endpackage

// File: rtl/tlane_cfg.sv
module tlane_cfg
    import tlane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  cfg_t cfg_in,
    input  logic busy,
    output cfg_t cfg_act
);
    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
        logic pending;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // apply the staged copy only in a cycle without a burst
        if (s_q.pending && !busy) begin
            s_d.active  = s_q.shadow;
            s_d.pending = 1'b0;
        end
        if (cfg_load) begin
            s_d.shadow  = cfg_in;
            s_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_act = s_q.active;
endmodule

// File: rtl/tlane_fanout.sv
module tlane_fanout
    import tlane_pkg::*;
#(
    parameter int LANES = 9
) (
    input  cfg_t                      cfg,
    input  logic [WORD_W-1:0]         word,
    output logic [LANES*BYTE_W-1:0]   bus_e,
    output logic [LANES*BYTE_W-1:0]   bus_l
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic hit;
        assign hit = (cfg.wr_sel == SEL_ALL) || (cfg.wr_sel == SEL_W'(n));
        assign bus_e[n*BYTE_W +: BYTE_W] = hit ? word[BYTE_W-1:0]      : cfg.fill_e;
        assign bus_l[n*BYTE_W +: BYTE_W] = hit ? word[WORD_W-1:BYTE_W] : cfg.fill_l;
    end
endmodule

// File: rtl/tlane_pick.sv
module tlane_pick
    import tlane_pkg::*;
#(
    parameter int LANES = 9
) (
    input  logic [SEL_W-1:0]        sel,
    input  logic [LANES*BYTE_W-1:0] bus_e,
    input  logic [LANES*BYTE_W-1:0] bus_l,
    output logic [WORD_W-1:0]       word
);
    always_comb begin
        word = '0;
        for (int n = 0; n < LANES; n++) begin
            if (sel == SEL_W'(n)) begin
                word = {bus_l[n*BYTE_W +: BYTE_W], bus_e[n*BYTE_W +: BYTE_W]};
            end
        end
    end
endmodule

// File: rtl/tlane_access.sv
module tlane_access
    import tlane_pkg::*;
#(
    parameter int LANES = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic                    cfg_enable,
    input  logic [SEL_W-1:0]        cfg_rd_lane,
    input  logic [SEL_W-1:0]        cfg_wr_lane,
    input  logic [BYTE_W-1:0]       cfg_fill_early,
    input  logic [BYTE_W-1:0]       cfg_fill_late,
    input  logic                    wr_go,
    input  logic                    rd_go,
    input  logic [WORD_W-1:0]       tdata_in,
    input  logic [LANES*BYTE_W-1:0] dq_rd_early,
    input  logic [LANES*BYTE_W-1:0] dq_rd_late,
    output logic [LANES*BYTE_W-1:0] dq_wr_early,
    output logic [LANES*BYTE_W-1:0] dq_wr_late,
    output logic                    dq_wr_valid,
    output logic [WORD_W-1:0]       status_out,
    output logic                    status_valid,
    output logic                    mismatch
);
    localparam int BUS_W = LANES * BYTE_W;

    typedef struct packed {
        logic [BUS_W-1:0]  wr_e;
        logic [BUS_W-1:0]  wr_l;
        logic              wr_v;
        logic [WORD_W-1:0] st;
        logic              st_v;
        logic              mis;
    } out_t;

    cfg_t              cfg_new, cfg_act;
    logic [BUS_W-1:0]  fan_e, fan_l;
    logic [WORD_W-1:0] rd_word, cmp_word;
    out_t              o_d, o_q;

    assign cfg_new = '{en: cfg_enable, rd_sel: cfg_rd_lane, wr_sel: cfg_wr_lane,
                       fill_e: cfg_fill_early, fill_l: cfg_fill_late};

    tlane_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_load(cfg_load),
        .cfg_in  (cfg_new),
        .busy    (wr_go | rd_go),
        .cfg_act (cfg_act)
    );

    tlane_fanout #(.LANES(LANES)) u_fan (
        .cfg  (cfg_act),
        .word (tdata_in),
        .bus_e(fan_e),
        .bus_l(fan_l)
    );

    tlane_pick #(.LANES(LANES)) u_pick_rd (
        .sel  (cfg_act.rd_sel),
        .bus_e(dq_rd_early),
        .bus_l(dq_rd_late),
        .word (rd_word)
    );

    tlane_pick #(.LANES(LANES)) u_pick_cmp (
        .sel  (cfg_act.wr_sel),
        .bus_e(dq_rd_early),
        .bus_l(dq_rd_late),
        .word (cmp_word)
    );

    always_comb begin
        o_d      = o_q;
        o_d.wr_v = 1'b0;
        o_d.st_v = 1'b0;
        if (cfg_act.en && wr_go) begin
            o_d.wr_e = fan_e;
            o_d.wr_l = fan_l;
            o_d.wr_v = 1'b1;
        end
        if (cfg_act.en && rd_go) begin
            o_d.st   = rd_word;
            o_d.st_v = 1'b1;
            o_d.mis  = (cmp_word != tdata_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dq_wr_early  = o_q.wr_e;
    assign dq_wr_late   = o_q.wr_l;
    assign dq_wr_valid  = o_q.wr_v;
    assign status_out   = o_q.st;
    assign status_valid = o_q.st_v;
    assign mismatch     = o_q.mis;
endmodule

// File: rtl/tlane_access_chk.sv
module tlane_access_chk
    import tlane_pkg::*;
#(
    parameter int LANES = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_go,
    input logic                    rd_go,
    input logic                    act_en,
    input logic [SEL_W-1:0]        act_rd_sel,
    input logic [$bits(cfg_t)-1:0] act_cfg,
    input logic                    dq_wr_valid,
    input logic [LANES*BYTE_W-1:0] dq_wr_early,
    input logic                    status_valid,
    input logic [WORD_W-1:0]       status_out,
    input logic                    mismatch
);
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> (!dq_wr_valid && !status_valid));

    assert_wr_valid_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_wr_valid |-> $past(wr_go));

    assert_rd_valid_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> $past(rd_go));

    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_wr_valid |-> $stable(dq_wr_early));

    assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !status_valid |-> ($stable(status_out) && $stable(mismatch)));

    assert_no_lane_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && ($past(act_rd_sel) >= SEL_W'(LANES))) |-> (status_out == '0));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go || rd_go) |=> $stable(act_cfg));
endmodule

bind tlane_access tlane_access_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_go       (wr_go),
    .rd_go       (rd_go),
    .act_en      (cfg_act.en),
    .act_rd_sel  (cfg_act.rd_sel),
    .act_cfg     (cfg_act),
    .dq_wr_valid (dq_wr_valid),
    .dq_wr_early (dq_wr_early),
    .status_valid(status_valid),
    .status_out  (status_out),
    .mismatch    (mismatch)
);

// File: tb/tlane_access_bench.sv
`timescale 1ns/1ps
module tlane_access_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0, cfg_enable = 1'b0;
    logic [3:0]  cfg_rd_lane = '0, cfg_wr_lane = '0;
    logic [7:0]  cfg_fill_early = '0, cfg_fill_late = '0;
    logic        wr_go = 1'b0, rd_go = 1'b0;
    logic [15:0] tdata_in = '0;
    logic [71:0] dq_rd_early = '0, dq_rd_late = '0;
    logic [71:0] dq_wr_early, dq_wr_late;
    logic        dq_wr_valid, status_valid, mismatch;
    logic [15:0] status_out;

    int n_chk = 0, n_fail = 0;
    // model of the active configuration
    logic       m_en = 1'b0;
    logic [3:0] m_rs = '0, m_ws = '0;
    logic [7:0] m_fe = '0, m_fl = '0;
    // model of the held outputs
    logic [71:0] h_e = '0, h_l = '0;
    logic [15:0] h_st = '0;
    logic        h_mis = 1'b0;

    always #10 clk = ~clk;

    tlane_access u_tlane_access (.*);

    function automatic logic [71:0] exp_bus(input logic [3:0] sel, input logic [7:0] d,
                                            input logic [7:0] fill);
        logic [71:0] b;
        for (int n = 0; n < 9; n++) b[n*8 +: 8] = (sel == 4'hF || sel == 4'(n)) ? d : fill;
        return b;
    endfunction

    function automatic logic [15:0] exp_pick(input logic [3:0] sel, input logic [71:0] e,
                                             input logic [71:0] l);
        if (sel > 4'd8) return 16'h0;
        return {l[sel*8 +: 8], e[sel*8 +: 8]};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // staged load followed by one idle cycle so the copy becomes active (R9)
    task automatic set_cfg(input logic en, input logic [3:0] rs, input logic [3:0] ws,
                           input logic [7:0] fe, input logic [7:0] fl);
        cfg_enable = en; cfg_rd_lane = rs; cfg_wr_lane = ws;
        cfg_fill_early = fe; cfg_fill_late = fl; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
        m_en = en; m_rs = rs; m_ws = ws; m_fe = fe; m_fl = fl;
    endtask

    task automatic do_write(input logic [15:0] d, input string req);
        tdata_in = d; wr_go = 1'b1;
        @(negedge clk);
        wr_go = 1'b0;
        if (m_en) begin
            h_e = exp_bus(m_ws, d[7:0], m_fe);
            h_l = exp_bus(m_ws, d[15:8], m_fl);
            check({req, " wr_valid"}, 72'(dq_wr_valid), 72'(1));
        end else begin
            check("R1 wr_valid low", 72'(dq_wr_valid), 72'(0));
        end
        check({req, " early bus"}, dq_wr_early, h_e);
        check({req, " late bus"}, dq_wr_late, h_l);
    endtask

    task automatic do_read(input logic [71:0] e, input logic [71:0] l,
                           input logic [15:0] d, input string req);
        dq_rd_early = e; dq_rd_late = l; tdata_in = d; rd_go = 1'b1;
        @(negedge clk);
        rd_go = 1'b0;
        if (m_en) begin
            h_st  = exp_pick(m_rs, e, l);
            h_mis = (exp_pick(m_ws, e, l) != d);
            check({req, " status_valid"}, 72'(status_valid), 72'(1));
        end else begin
            check("R1 status_valid low", 72'(status_valid), 72'(0));
        end
        check({req, " status_out"}, 72'(status_out), 72'(h_st));
        check("R8 mismatch", 72'(mismatch), 72'(h_mis));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [71:0] e, l;
        logic [15:0] d;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 wr_early", dq_wr_early, '0);
        check("R10 wr_late", dq_wr_late, '0);
        check("R10 status", {55'(0), status_valid, status_out}, '0);
        check("R10 flags", {70'(0), dq_wr_valid, mismatch}, '0);
        // R1 disabled after reset: bursts ignored
        do_write(16'hBEEF, "R1");
        do_read({9{8'h11}}, {9{8'h22}}, 16'h1234, "R1");

        // directed lane cases
        set_cfg(1'b1, 4'd3, 4'd0, 8'hA5, 8'h5A);
        do_write(16'h3C7E, "R2 R3 lane0");
        set_cfg(1'b1, 4'd8, 4'd8, 8'h01, 8'h02);
        do_write(16'hF00D, "R2 R3 lane8");
        set_cfg(1'b1, 4'd0, 4'hF, 8'h01, 8'h02);
        do_write(16'hC3A9, "R4 broadcast");
        set_cfg(1'b1, 4'd9, 4'd9, 8'h77, 8'h88);
        do_write(16'h1234, "R5 code9");
        set_cfg(1'b1, 4'd14, 4'd14, 8'h66, 8'h99);
        do_write(16'h4321, "R5 code14");
        e = 72'h0807_0605_0403_0201_00; l = 72'h1817_1615_1413_1211_10;
        do_read(e, l, 16'h0000, "R7 code14 R8 zero word");
        set_cfg(1'b1, 4'hF, 4'd4, 8'h00, 8'h00);
        do_read(e, l, 16'h1404, "R7 code15 R8 match");
        set_cfg(1'b1, 4'd6, 4'd6, 8'h00, 8'h00);
        do_read(e, l, 16'h1606, "R6 lane6 R8 match");
        do_read(e, l, 16'h1607, "R6 lane6 R8 differ");

        // R9 staged load during back-to-back writes keeps old lane 2
        set_cfg(1'b1, 4'd0, 4'd2, 8'h10, 8'h20);
        cfg_enable = 1'b1; cfg_rd_lane = 4'd0; cfg_wr_lane = 4'd5;
        cfg_fill_early = 8'h30; cfg_fill_late = 8'h40;
        cfg_load = 1'b1; tdata_in = 16'hABCD; wr_go = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R9 old config kept early", dq_wr_early, exp_bus(4'd2, 8'hCD, 8'h10));
            check("R9 old config kept late", dq_wr_late, exp_bus(4'd2, 8'hAB, 8'h20));
            @(negedge clk);
        end
        wr_go = 1'b0;
        h_e = exp_bus(4'd2, 8'hCD, 8'h10); h_l = exp_bus(4'd2, 8'hAB, 8'h20);
        @(negedge clk);
        check("R11 valid dropped", 72'(dq_wr_valid), 72'(0));
        m_ws = 4'd5; m_fe = 8'h30; m_fl = 8'h40; m_rs = 4'd0;
        do_write(16'hABCD, "R9 new config");

        // R1 disable holds outputs
        set_cfg(1'b0, 4'd1, 4'd1, 8'hFF, 8'hFF);
        do_write(16'h5555, "R1");
        do_read({9{8'hEE}}, {9{8'hDD}}, 16'h0, "R1");

        // constrained random
        for (int i = 0; i < 300; i++) begin
            set_cfg(($urandom % 8) != 0, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                    8'($urandom), 8'($urandom));
            do_write(16'($urandom), "R2 R3 R4 R5 random");
            e = {8'($urandom), $urandom, $urandom};
            l = {8'($urandom), $urandom, $urandom};
            d = ($urandom % 2) ? exp_pick(m_ws, e, l) : 16'($urandom);
            do_read(e, l, d, "R6 R7 random");
            @(negedge clk);
            check("R11 pulses", {70'(0), dq_wr_valid, status_valid}, '0);
        end
        summary();
    end
endmodule